// File: doc/BRIEF.md
# Pulse-swallow dual-modulus feedback divider

This block is the control logic of a synthesizer feedback divider built around an external prescaler that divides by 64 or by 65. It is clocked by the prescaler output. A 12-bit main counter sets the length of one feedback cycle in prescaler pulses (N). A 6-bit swallow counter sets how many of those pulses come from divide-by-65 periods (A). The block drives the prescaler's modulus-select line, so one feedback cycle spans 64·N + A input edges. The largest cycle, with N = 4095 and A = 63, is 262,143 edges. Once per cycle it emits a one-clock pulse to the phase detector.

A new (N, A) pair is written into a holding register at any time. The counters take their reload values from that register only at the wrap edge that ends a cycle. A cycle in progress is therefore never disturbed. A write that arrives on the wrap edge itself misses that reload and is applied at the following one. The ratio pair must satisfy N ≥ 1 and A ≤ N.

Top module: `psd_feedback_div`

## Requirements
- R1: After a synchronous active-low reset, the holding register contains N = 8 and A = 3, fv_pulse is low and mod_sel is high. The first fv_pulse appears at the 8th clock after reset is released. The first full cycle that follows spans 515 input edges.
- R2: A write uses wr_data[17:6] as N and wr_data[5:0] as A. Once the write is applied, successive fv_pulse rises are separated by 64·N + A input edges, where a clock with mod_sel high counts 65 edges and a clock with mod_sel low counts 64.
- R3: In each cycle mod_sel is high (divide by 65) for exactly the first A prescaler periods and low for the rest. It never rises again before the cycle ends.
- R4: With A = 0, mod_sel stays low for the whole cycle. With A = N, it stays high for the whole cycle.
- R5: For N ≥ 2, fv_pulse is high for exactly one clock per cycle, in the first period of the cycle, and a cycle lasts N clocks.
- R6: A write that lands in the middle of a cycle does not change that cycle. It applies from the next cycle.
- R7: A write sampled on the wrap edge that reloads the counters is held off. The cycle that this edge starts still uses the previous ratio, and the new ratio applies one cycle later.
- R8: If several writes land within one cycle, only the last one takes effect at the next reload.
- R9: The maximum setting N = 4095 and A = 63 gives a cycle of 262,143 input edges.
- R10: With N = 1, every prescaler pulse ends a cycle and fv_pulse stays high continuously. The cycle length is 64 + A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output pulse train; clocks all state |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 18 | Ratio word: N in bits 17:6, A in bits 5:0 |
| mod_sel | output | 1 | Modulus select to the prescaler: 1 = divide by 65, 0 = divide by 64 |
| fv_pulse | output | 1 | One-clock feedback pulse to the phase detector |

## Verification
mod_sel is a decode of the swallow counter register, so it reflects a prescaler edge one clock after that edge. fv_pulse is registered from the wrap condition and is high in the clock that follows the wrap edge. A write captured at an edge takes effect at the first wrap edge strictly after that capture. The bench drives and samples on falling edges and acts as the prescaler by adding 64 or 65 per clock. It measures each cycle from one fv_pulse clock up to the next, and it places each write on a counted period index: mid-cycle, on the last period before the wrap edge, or twice within one cycle.

// File: rtl/psd_pkg.sv
// Shared widths and the ratio type for the pulse-swallow feedback divider.
// Assumes a fixed 64/65 external prescaler; only the counter widths vary.
package psd_pkg;
    localparam int A_W     = 6;            // swallow counter width
    localparam int N_W     = 12;           // main counter width
    localparam int RATIO_W = N_W + A_W;    // written ratio word width

    // Ratio word: N in the upper field, A in the lower field.
    typedef struct packed {
        logic [N_W-1:0] n;
        logic [A_W-1:0] a;
    } ratio_t;
endpackage

// File: rtl/psd_ratio_buf.sv
// Holding register for the next (N, A) pair. It is written at any time.
// The counters read it only at their wrap edge, so a write that coincides
// with a wrap edge is seen at the following wrap. Assumes writes are
// synchronous to the prescaler output clock.
module psd_ratio_buf
    import psd_pkg::*;
#(
    parameter int DEF_N = 8,
    parameter int DEF_A = 3
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   wr_en,
    input  ratio_t wr_ratio,
    output ratio_t hold_q
);
    localparam logic [N_W-1:0] RST_N_VAL = N_W'(DEF_N);
    localparam logic [A_W-1:0] RST_A_VAL = A_W'(DEF_A);

    // Capture a new ratio on a write; keep it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q.n <= RST_N_VAL;
            hold_q.a <= RST_A_VAL;
        end else if (wr_en) begin
            hold_q <= wr_ratio;
        end
    end

    // R2: a written pair must be legal (N at least 1, A no larger than N)
    a_r2_legal_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_ratio.n != '0) && ({{(N_W-A_W){1'b0}}, wr_ratio.a} <= wr_ratio.n));

    // R6: without a write the held ratio does not move
    a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(hold_q));
endmodule

// File: rtl/psd_main_cnt.sv
// Main (N) counter. It counts prescaler pulses down from N to 1 and flags
// the wrap when it holds 1. At the wrap edge it reloads and registers the
// one-clock feedback pulse. Assumes the reload value is never zero.
module psd_main_cnt
    import psd_pkg::*;
#(
    parameter int DEF_N = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N_W-1:0] reload_n,
    output logic [N_W-1:0] n_rem,
    output logic           wrap,
    output logic           fv_q
);
    localparam logic [N_W-1:0] ONE = N_W'(1);

    // Last period of the cycle: the next edge ends it.
    always_comb begin
        wrap = (n_rem == ONE);
    end

    // Count down, reload at the wrap, and register the feedback pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_rem <= N_W'(DEF_N);
            fv_q  <= 1'b0;
        end else begin
            fv_q  <= wrap;
            n_rem <= wrap ? reload_n : (n_rem - ONE);
        end
    end

    // R5: the pulse lasts one clock unless the cycle is a single period
    a_r5_fv_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (fv_q && (n_rem != ONE)) |=> !fv_q);

    // R2: the remaining count never reaches zero
    a_r2_n_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        n_rem != '0);
endmodule

// File: rtl/psd_swallow_cnt.sv
// Swallow (A) counter. It counts the divide-by-65 periods at the start of
// each cycle. The prescaler selects divide-by-65 while the count is nonzero.
// The counter saturates at zero until the main counter wraps.
module psd_swallow_cnt
    import psd_pkg::*;
#(
    parameter int DEF_A = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wrap,
    input  logic [A_W-1:0] reload_a,
    output logic [A_W-1:0] a_rem,
    output logic           mod_hi
);
    // Divide by 65 while swallow periods remain.
    always_comb begin
        mod_hi = (a_rem != '0);
    end

    // Reload at the wrap; otherwise count down to zero and stay there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_rem <= A_W'(DEF_A);
        end else if (wrap) begin
            a_rem <= reload_a;
        end else if (a_rem != '0) begin
            a_rem <= a_rem - A_W'(1);
        end
    end

    // R3: divide-by-65 can only start at the beginning of a cycle
    a_r3_mod_rise_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mod_hi) |-> $past(wrap));
endmodule

// File: rtl/psd_feedback_div.sv
// Top of the pulse-swallow feedback divider. It is clocked by the 64/65
// prescaler output and drives the modulus select and the feedback pulse.
// One cycle lasts 64*N + A prescaler input edges. Assumes N >= 1, A <= N,
// and writes synchronous to clk.
module psd_feedback_div
    import psd_pkg::*;
#(
    parameter int DEF_N = 8,
    parameter int DEF_A = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [RATIO_W-1:0] wr_data,
    output logic               mod_sel,
    output logic               fv_pulse
);
    ratio_t         wr_ratio;
    ratio_t         hold_q;
    logic [N_W-1:0] n_rem;
    logic [A_W-1:0] a_rem;
    logic           wrap;
    logic           fv_q;
    logic           mod_hi;

    // Split the write word into its fields.
    always_comb begin
        wr_ratio = ratio_t'(wr_data);
    end

    psd_ratio_buf #(.DEF_N(DEF_N), .DEF_A(DEF_A)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_ratio (wr_ratio),
        .hold_q   (hold_q)
    );

    psd_main_cnt #(.DEF_N(DEF_N)) u_main (
        .clk      (clk),
        .rst_n    (rst_n),
        .reload_n (hold_q.n),
        .n_rem    (n_rem),
        .wrap     (wrap),
        .fv_q     (fv_q)
    );

    psd_swallow_cnt #(.DEF_A(DEF_A)) u_swallow (
        .clk      (clk),
        .rst_n    (rst_n),
        .wrap     (wrap),
        .reload_a (hold_q.a),
        .a_rem    (a_rem),
        .mod_hi   (mod_hi)
    );

    // Drive the outputs from the counter stages.
    always_comb begin
        mod_sel  = mod_hi;
        fv_pulse = fv_q;
    end

    // R3: swallow periods left never exceed the periods left in the cycle
    a_r3_swallow_bound: assert property (@(posedge clk) disable iff (!rst_n)
        {{(N_W-A_W){1'b0}}, a_rem} <= n_rem);
endmodule

// File: tb/psd_feedback_div_bench.sv
// Directed bench. The 50 MHz clock stands in for the prescaler output. The
// prescaler is modelled by adding 64 or 65 input edges per clock according
// to mod_sel. Inputs are driven and outputs sampled on falling edges.
module psd_feedback_div_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [17:0] wr_data = '0;
    logic        mod_sel;
    logic        fv_pulse;

    int  n_total = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    always #10 clk = ~clk;

    psd_feedback_div u_psd_feedback_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .mod_sel  (mod_sel),
        .fv_pulse (fv_pulse)
    );

    function automatic logic [17:0] word(input int n, input int a);
        return {12'(n), 6'(a)};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Write one word at a falling edge; return one falling edge later.
    task automatic write_now(input logic [17:0] w);
        wr_en = 1'b1;
        wr_data = w;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Step at least once, then stop at the first falling edge with fv high.
    task automatic sync_fv();
        int guard = 0;
        @(negedge clk);
        while (fv_pulse !== 1'b1 && guard < 10000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    // Measure one cycle starting at a falling edge with fv high. Writes may
    // be placed at period indices k1 and k2 (-1 for none).
    task automatic measure(input int k1, input logic [17:0] w1,
                           input int k2, input logic [17:0] w2,
                           output int sum, output int highs,
                           output int periods, output bit ordered);
        bit fell = 1'b0;
        sum = 0; highs = 0; periods = 0; ordered = 1'b1;
        do begin
            if (periods == k1) begin wr_en = 1'b1; wr_data = w1; end
            else if (periods == k2) begin wr_en = 1'b1; wr_data = w2; end
            if (mod_sel) begin
                highs++;
                if (fell) ordered = 1'b0;
            end else begin
                fell = 1'b1;
            end
            sum += mod_sel ? 65 : 64;
            periods++;
            @(negedge clk);
            wr_en = 1'b0;
        end while (fv_pulse !== 1'b1 && periods < 10000);
    endtask

    task automatic t_reset();
        int cnt = 0;
        int s, h, p;
        bit o;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(fv_pulse === 1'b0, "R1 fv low in reset", int'(fv_pulse), 0);
        check(mod_sel === 1'b1, "R1 mod_sel high in reset", int'(mod_sel), 1);
        rst_n = 1'b1;
        do begin
            @(negedge clk);
            cnt++;
        end while (fv_pulse !== 1'b1 && cnt < 100);
        check(cnt == 8, "R1 first fv clock", cnt, 8);
        measure(-1, '0, -1, '0, s, h, p, o);
        check(s == 515, "R1 default ratio", s, 515);
    endtask

    task automatic t_ratio(input int n, input int a, input string req);
        int s, h, p;
        bit o;
        write_now(word(n, a));
        sync_fv();
        measure(-1, '0, -1, '0, s, h, p, o);
        check(s == 64 * n + a, {req, " cycle edges"}, s, 64 * n + a);
        check(h == a, "R3 divide-by-65 periods", h, a);
        check(o, "R3 swallow periods first", int'(o), 1);
        check(p == n, "R5 periods per cycle", p, n);
    endtask

    task automatic t_n_one(input int a);
        int s, h, p;
        bit o;
        write_now(word(1, a));
        sync_fv();
        for (int i = 0; i < 4; i++) begin
            check(fv_pulse === 1'b1, "R10 fv stays high", int'(fv_pulse), 1);
            check(mod_sel === (a != 0), "R10 modulus", int'(mod_sel), int'(a != 0));
            @(negedge clk);
        end
        measure(-1, '0, -1, '0, s, h, p, o);
        check(s == 64 + a, "R10 cycle edges", s, 64 + a);
    endtask

    task automatic t_midcycle();
        int s, h, p;
        bit o;
        write_now(word(12, 4));
        sync_fv();
        measure(5, word(30, 2), -1, '0, s, h, p, o);
        check(s == 772, "R6 cycle with mid write unchanged", s, 772);
        measure(-1, '0, -1, '0, s, h, p, o);
        check(s == 1922, "R6 next cycle uses new ratio", s, 1922);
        check(h == 2, "R6 new swallow count", h, 2);
    endtask

    task automatic t_at_wrap();
        int s, h, p;
        bit o;
        // current ratio is (30,2); write on the last period, sampled at wrap
        measure(29, word(9, 9), -1, '0, s, h, p, o);
        check(s == 1922, "R7 cycle holding the write", s, 1922);
        measure(-1, '0, -1, '0, s, h, p, o);
        check(s == 1922, "R7 reload at write edge keeps old ratio", s, 1922);
        measure(-1, '0, -1, '0, s, h, p, o);
        check(s == 585, "R7 new ratio one cycle later", s, 585);
    endtask

    task automatic t_last_wins();
        int s, h, p;
        bit o;
        // current ratio is (9,9)
        measure(1, word(6, 2), 3, word(7, 5), s, h, p, o);
        check(s == 585, "R8 cycle with two writes", s, 585);
        measure(-1, '0, -1, '0, s, h, p, o);
        check(s == 453, "R8 last write wins", s, 453);
        check(h == 5, "R8 swallow count of last write", h, 5);
    endtask

    initial begin
        t_reset();
        t_ratio(20, 7, "R2");
        t_ratio(10, 0, "R4 A zero");
        t_ratio(5, 5, "R4 A equals N");
        t_midcycle();
        t_at_wrap();
        t_last_wins();
        t_ratio(4095, 63, "R9 maximum");
        t_n_one(0);
        t_n_one(1);
        t_ratio(3, 1, "R2 after single-period cycles");
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_total++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end
endmodule